// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a small processor core and handles the moment at which a reset request or a hardware interrupt is taken. The core raises `boundary` for one cycle at the end of each instruction. At that point the block looks at the pending reset request, the pending-source mask, the global interrupt enable and the skip-pending flag, and decides whether to take an entry.

After an entry is taken, the block saves the return word address on a byte-wide stack that grows downward. It issues one byte write per clock through a simple memory write port. It then computes the vector address and produces the new program counter, the new stack pointer and the updated pending mask. It also gives a one-cycle strobe that tells the status register to clear the global enable.

Two straps select the byte count of the return address and whether vectors are one or two words apart. While a sequence runs, the block ignores further boundary strobes.

Top module: `irq_entry_seq`

## Requirements
- R1: When `skip_pend` is high at a boundary, nothing is accepted: no stack write and no `done` follow, and `pc_o` keeps its value.
- R2: When `gie` is low at a boundary, neither a reset request nor a hardware source is accepted.
- R3: A reset request takes priority over hardware sources. It uses vector index 0, so `pc_o` becomes 0, and `pend_o` is the sampled pending mask left unchanged.
- R4: Among hardware sources, the lowest-numbered set bit of `pend_i` wins. Its vector index is its bit position plus one.
- R5: The new PC is the vector index times 2 when `long_vec` is 1, and the vector index times 1 when `long_vec` is 0.
- R6: The return address is written one byte per clock. The first write goes to the sampled SP, and each later write goes to an address one lower. The low byte goes first, then bits 15:8, then bits 23:16 of the zero-extended PC.
- R7: The `pc_bytes` strap sets the number of bytes written: 0 or 1 gives one byte, 2 gives two bytes, and 3 gives three bytes.
- R8: `sp_o` becomes the sampled SP minus the byte count, modulo 2^16.
- R9: For a hardware entry, the serviced bit is cleared in `pend_o`. `hw_req` stays high exactly when some bit of `pend_o` is still set.
- R10: `done` and `ie_clr` are high together for exactly one cycle, in the cycle after the last stack write. `pc_o`, `sp_o` and `pend_o` are valid from that cycle and hold their values until the next `done`.
- R11: A boundary that arrives while `busy` is high has no effect. A boundary with no reset request and an all-zero mask is not accepted.
- R12: After a synchronous reset, `busy`, `done`, `wr_en` and `ie_clr` are low, and `pc_o`, `sp_o` and `pend_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction-boundary strobe; acceptance is evaluated here |
| rst_req | input | 1 | Pending reset request |
| pend_i | input | 32 | Pending hardware source mask |
| gie | input | 1 | Global interrupt enable |
| skip_pend | input | 1 | An instruction skip is pending |
| pc_i | input | 22 | Current PC (word address), used as the return address |
| sp_i | input | 16 | Current stack pointer |
| pc_bytes | input | 2 | Strap: return address size in bytes |
| long_vec | input | 1 | Strap: vectors are two words apart |
| busy | output | 1 | An entry sequence is in progress |
| wr_en | output | 1 | Stack byte write strobe |
| wr_addr | output | 16 | Stack write address |
| wr_data | output | 8 | Stack write data |
| done | output | 1 | Entry complete; new PC and SP are valid |
| ie_clr | output | 1 | Clear the global interrupt enable |
| pc_o | output | 22 | New PC (vector address) |
| sp_o | output | 16 | New stack pointer |
| pend_o | output | 32 | Pending mask after servicing |
| hw_req | output | 1 | Hardware sources still pending after servicing |

## Verification
The bench targets the cases where the priority choice or the stack arithmetic can go wrong quietly. These are a reset request that arrives together with hardware bits, the highest source bit 31 with long vectors (index 32 gives PC 64), and a mask with two set bits.

- If a design got the priority wrong, it would vector somewhere other than 0, or it would clear a hardware bit during a reset entry.
- If it got the index off by one, it would vector to the bit position itself.
- If its stack arithmetic were wrong, the stack pointer would fail to wrap from 0x0000 to 0xFFFF. The byte order on the stack would be reversed, or the high byte would be dropped for a 3-byte PC.

A further test fires a second boundary during a push. A design that does not guard against this would restart the sequence or emit a second `done`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PUSH = 2'd1,
    S_LOAD = 2'd2
  } seq_state_e;

  localparam int RET_BYTES = 3;
  localparam int RET_W     = 8 * RET_BYTES;

  // strap value to number of stack bytes (0 treated as 1)
  function automatic logic [1:0] push_count(input logic [1:0] strap);
    case (strap)
      2'd2:    push_count = 2'd2;
      2'd3:    push_count = 2'd3;
      default: push_count = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int SRC_W = 32,
  localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic [SRC_W-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [SRC_W-1:0] rest
);

  // lowest set bit wins: scan from the top so the lowest overwrites last
  always_comb begin
    idx = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end

  assign any  = |pend;
  assign rest = pend & (pend - SRC_W'(1));

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int SRC_W = 32,
  parameter int PC_W  = 22,
  localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1,
  localparam int VI_W  = $clog2(SRC_W + 1)
) (
  input  logic             hw_sel,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             long_vec,
  output logic [PC_W-1:0]  vec_pc
);

  logic [VI_W-1:0] vidx;

  // reset uses index 0; hardware source n uses n+1
  assign vidx = hw_sel ? (VI_W'(bit_idx) + VI_W'(1)) : '0;

  generate
    if (PC_W > VI_W) begin : g_wide
      assign vec_pc = long_vec ? {PC_W'(vidx), 1'b0} >> 0 : PC_W'(vidx);
    end else begin : g_narrow
      assign vec_pc = long_vec ? PC_W'({vidx, 1'b0}) : PC_W'(vidx);
    end
  endgenerate

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int PC_W  = 22,
  parameter int SP_W  = 16,
  localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             rst_req,
  input  logic [SRC_W-1:0] pend_i,
  input  logic             gie,
  input  logic             skip_pend,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [SP_W-1:0]  sp_i,
  input  logic [1:0]       pc_bytes,
  input  logic             long_vec,
  output logic             busy,
  output logic             wr_en,
  output logic [SP_W-1:0]  wr_addr,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic             ie_clr,
  output logic [PC_W-1:0]  pc_o,
  output logic [SP_W-1:0]  sp_o,
  output logic [SRC_W-1:0] pend_o,
  output logic             hw_req
);

  seq_state_e       state;
  logic [RET_W-1:0] ret_r;
  logic [SP_W-1:0]  sp_r;
  logic [1:0]       cnt_r;
  logic [1:0]       nbytes_r;
  logic [PC_W-1:0]  vec_r;
  logic [SRC_W-1:0] pend_next_r;

  logic             any_hw;
  logic [IDX_W-1:0] win_idx;
  logic [SRC_W-1:0] pend_rest;
  logic [PC_W-1:0]  vec_pc;
  logic             take;
  logic             take_rst;
  logic [7:0]       cur_byte;

  irq_pick #(.SRC_W(SRC_W)) u_pick (
    .pend (pend_i),
    .any  (any_hw),
    .idx  (win_idx),
    .rest (pend_rest)
  );

  irq_vec_addr #(.SRC_W(SRC_W), .PC_W(PC_W)) u_vec (
    .hw_sel   (!rst_req),
    .bit_idx  (win_idx),
    .long_vec (long_vec),
    .vec_pc   (vec_pc)
  );

  assign take_rst = rst_req;
  assign take     = (state == S_IDLE) && boundary && !skip_pend && gie &&
                    (rst_req || any_hw);
  assign busy     = (state != S_IDLE);
  assign hw_req   = |pend_o;

  always_comb begin
    case (cnt_r)
      2'd0:    cur_byte = ret_r[7:0];
      2'd1:    cur_byte = ret_r[15:8];
      default: cur_byte = ret_r[23:16];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ret_r       <= '0;
      sp_r        <= '0;
      cnt_r       <= '0;
      nbytes_r    <= '0;
      vec_r       <= '0;
      pend_next_r <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      done        <= 1'b0;
      ie_clr      <= 1'b0;
      pc_o        <= '0;
      sp_o        <= '0;
      pend_o      <= '0;
    end else begin
      done   <= 1'b0;
      ie_clr <= 1'b0;
      case (state)
        S_IDLE: begin
          wr_en <= 1'b0;
          if (take) begin
            state       <= S_PUSH;
            ret_r       <= RET_W'(pc_i);
            sp_r        <= sp_i;
            cnt_r       <= '0;
            nbytes_r    <= push_count(pc_bytes);
            vec_r       <= vec_pc;
            pend_next_r <= take_rst ? pend_i : pend_rest;
          end
        end
        S_PUSH: begin
          wr_en   <= 1'b1;
          wr_addr <= sp_r;
          wr_data <= cur_byte;
          sp_r    <= sp_r - SP_W'(1);
          cnt_r   <= cnt_r + 2'd1;
          if (cnt_r + 2'd1 == nbytes_r) state <= S_LOAD;
        end
        S_LOAD: begin
          wr_en  <= 1'b0;
          done   <= 1'b1;
          ie_clr <= 1'b1;
          pc_o   <= vec_r;
          sp_o   <= sp_r;
          pend_o <= pend_next_r;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int SP_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            boundary,
  input logic            gie,
  input logic            skip_pend,
  input logic            busy,
  input logic            wr_en,
  input logic [SP_W-1:0] wr_addr,
  input logic            done,
  input logic            ie_clr
);

  p_skip_blocks_r1: assert property (@(posedge clk) disable iff (rst)
    (boundary && skip_pend && !busy) |=> !busy);

  p_gie_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (boundary && !gie && !busy) |=> !busy);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - SP_W'(1)));

  p_write_in_seq_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_en) && !wr_en && !busy));

  p_ieclr_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    ie_clr |-> done);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .boundary  (boundary),
  .gie       (gie),
  .skip_pend (skip_pend),
  .busy      (busy),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .done      (done),
  .ie_clr    (ie_clr)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        boundary;
  logic        rst_req;
  logic [31:0] pend_i;
  logic        gie;
  logic        skip_pend;
  logic [21:0] pc_i;
  logic [15:0] sp_i;
  logic [1:0]  pc_bytes;
  logic        long_vec;
  logic        busy, wr_en, done, ie_clr, hw_req;
  logic [15:0] wr_addr, sp_o;
  logic [7:0]  wr_data;
  logic [21:0] pc_o;
  logic [31:0] pend_o;

  int checks = 0;
  int errors = 0;
  logic [21:0] last_pc;

  always #4 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .boundary(boundary), .rst_req(rst_req),
    .pend_i(pend_i), .gie(gie), .skip_pend(skip_pend), .pc_i(pc_i),
    .sp_i(sp_i), .pc_bytes(pc_bytes), .long_vec(long_vec), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .ie_clr(ie_clr), .pc_o(pc_o), .sp_o(sp_o), .pend_o(pend_o),
    .hw_req(hw_req)
  );

  typedef struct packed {
    logic        rreq;
    logic [31:0] pend;
    logic        ie;
    logic        skip;
    logic [21:0] pc;
    logic [15:0] sp;
    logic [1:0]  strap;
    logic        lv;
    logic        acc;
    logic [21:0] exp_pc;
    logic [31:0] exp_pend;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 32'h0000_0004, 1'b1, 1'b0, 22'h001234, 16'h08FF, 2'd2, 1'b1, 1'b1, 22'd6,  32'h0000_0000},
    '{1'b0, 32'h8000_0000, 1'b1, 1'b0, 22'h2ABCDE, 16'h1000, 2'd3, 1'b1, 1'b1, 22'd64, 32'h0000_0000},
    '{1'b0, 32'h0000_0F00, 1'b1, 1'b0, 22'h000055, 16'h0200, 2'd1, 1'b0, 1'b1, 22'd9,  32'h0000_0E00},
    '{1'b1, 32'h0000_0010, 1'b1, 1'b0, 22'h000777, 16'h0300, 2'd2, 1'b1, 1'b1, 22'd0,  32'h0000_0010},
    '{1'b1, 32'h0000_0001, 1'b1, 1'b1, 22'h000100, 16'h0400, 2'd2, 1'b1, 1'b0, 22'd0,  32'h0000_0000},
    '{1'b1, 32'h0000_FFFF, 1'b0, 1'b0, 22'h000100, 16'h0400, 2'd2, 1'b1, 1'b0, 22'd0,  32'h0000_0000},
    '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 22'h000100, 16'h0400, 2'd2, 1'b1, 1'b0, 22'd0,  32'h0000_0000},
    '{1'b0, 32'h0000_0001, 1'b1, 1'b0, 22'h3FFFFF, 16'h0001, 2'd0, 1'b0, 1'b1, 22'd1,  32'h0000_0000},
    '{1'b0, 32'h0001_0001, 1'b1, 1'b0, 22'h03C0A5, 16'h0001, 2'd3, 1'b1, 1'b1, 22'd2,  32'h0001_0000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one case: pulse boundary, collect writes, check results
  task automatic run_case(input vec_t v, input bit extra_boundary, input string tag);
    int nb, nwr, done_k, ndone;
    logic [15:0] addrs [4];
    logic [7:0]  datas [4];
    logic [23:0] ret;
    @(negedge clk);
    rst_req = v.rreq; pend_i = v.pend; gie = v.ie; skip_pend = v.skip;
    pc_i = v.pc; sp_i = v.sp; pc_bytes = v.strap; long_vec = v.lv;
    boundary = 1'b1;
    nb = (v.strap == 2'd0) ? 1 : int'(v.strap);
    ret = {2'b00, v.pc};
    nwr = 0; done_k = -1; ndone = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      boundary = (extra_boundary && k == 0) ? 1'b1 : 1'b0;
      if (k == 0) boundary = extra_boundary;
      if (wr_en && nwr < 4) begin
        addrs[nwr] = wr_addr; datas[nwr] = wr_data;
        nwr++;
      end
      if (done) begin
        ndone++;
        if (done_k < 0) begin
          done_k = k;
          chk(ie_clr == 1'b1, "R10", {tag, " ie_clr with done"}, ie_clr, 1);
          chk(pc_o == v.exp_pc, "R4/R5 R3", {tag, " pc_o"}, pc_o, v.exp_pc);
          chk(sp_o == 16'(v.sp - 16'(nb)), "R8", {tag, " sp_o"}, sp_o, 16'(v.sp - 16'(nb)));
          chk(pend_o == v.exp_pend, "R9", {tag, " pend_o"}, pend_o, v.exp_pend);
          chk(hw_req == (v.exp_pend != 0), "R9", {tag, " hw_req"}, hw_req, v.exp_pend != 0);
        end
      end
    end
    boundary = 1'b0;
    if (v.acc) begin
      chk(nwr == nb, "R7", {tag, " write count"}, nwr, nb);
      chk(done_k == nb + 1, "R10", {tag, " done cycle"}, done_k, nb + 1);
      chk(ndone == 1, "R11 R10", {tag, " done count"}, ndone, 1);
      for (int j = 0; j < nb && j < nwr; j++) begin
        chk(addrs[j] == 16'(v.sp - 16'(j)), "R6", {tag, " write addr"}, addrs[j], 16'(v.sp - 16'(j)));
        chk(datas[j] == ret[8*j +: 8], "R6", {tag, " write byte"}, datas[j], ret[8*j +: 8]);
      end
      last_pc = v.exp_pc;
    end else begin
      chk(nwr == 0, "R1 R2 R11", {tag, " no writes"}, nwr, 0);
      chk(ndone == 0, "R1 R2 R11", {tag, " no done"}, ndone, 0);
      chk(pc_o == last_pc, "R1", {tag, " pc_o unchanged"}, pc_o, last_pc);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; boundary = 1'b0; rst_req = 1'b0; pend_i = '0; gie = 1'b0;
    skip_pend = 1'b0; pc_i = '0; sp_i = '0; pc_bytes = 2'd1; long_vec = 1'b0;
    last_pc = '0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !wr_en && !ie_clr, "R12", "control outputs", {busy, done, wr_en, ie_clr}, 0);
    chk(pc_o == 0 && sp_o == 0 && pend_o == 0, "R12", "data outputs", pc_o, 0);
    rst = 1'b0;
    @(negedge clk);

    // vector table walk (R1..R11)
    for (int i = 0; i < NV; i++) run_case(TBL[i], 1'b0, $sformatf("vec%0d", i));

    // R11: second boundary during push must be ignored
    run_case('{1'b0, 32'h0000_0006, 1'b1, 1'b0, 22'h012345, 16'h4000, 2'd3, 1'b0,
               1'b1, 22'd2, 32'h0000_0004}, 1'b1, "busy-boundary");

    // R11: no boundary, nothing happens even with sources pending
    @(negedge clk);
    rst_req = 1'b1; pend_i = 32'hFFFF_FFFF; gie = 1'b1; skip_pend = 1'b0; boundary = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(!busy && !wr_en && !done, "R11", "idle without boundary", busy, 0);
    end

    // R12: synchronous reset clears held results
    rst = 1'b1;
    @(negedge clk);
    chk(pc_o == 0 && sp_o == 0 && pend_o == 0 && !hw_req, "R12", "reset clears results", pc_o, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule